// File: doc/BRIEF.md
# Atomic Bit-Operation Register Bank

This block is a bank of 32-bit control registers on a word-wide request/response bus. Each register owns a 16-byte address window that holds four aliases of it. Address bits [3:2] do not select a different word. They choose how a write combines with the stored value: it can replace the value, OR bits in, clear the bits set in the data, or XOR bits in. Software can therefore flip or force single control bits without a read-modify-write sequence. A read at any of the four aliases returns the stored value.

Requests use a valid/ready handshake. `req_ready` is tied high, so the bank never applies back-pressure and accepts every cycle in which `req_valid` is high. Each accepted request produces exactly one response cycle, one clock later. The response carries read data and an error flag and cannot be stalled, so the requester must always accept it. Register k lives at byte offset 16·k. Only full, aligned 32-bit accesses to an existing register are valid.

Top module: `alias_reg_bank`

## Requirements
- R1: While reset is asserted and afterwards until the first write, every register holds zero and `rsp_valid` is low during reset.
- R2: A valid write with address bits [3:2] = 0 replaces the addressed register with `req_wdata`.
- R3: A valid write with address bits [3:2] = 1 sets the register bits that are 1 in `req_wdata` and leaves the others unchanged.
- R4: A valid write with address bits [3:2] = 2 clears the register bits that are 1 in `req_wdata` and leaves the others unchanged.
- R5: A valid write with address bits [3:2] = 3 inverts the register bits that are 1 in `req_wdata` and leaves the others unchanged.
- R6: A valid read at any of the four aliases returns the stored value in `rsp_rdata` one cycle after acceptance, and it reflects a write accepted in the previous cycle.
- R7: An access with address bits [1:0] not zero sets `rsp_err`, returns zero read data and changes no register.
- R8: An access with `req_be` not equal to 4'b1111 sets `rsp_err`, returns zero read data and changes no register.
- R9: An access whose register number (address bits above bit 3) is NUM_REGS or more sets `rsp_err`, returns zero read data and changes no register.
- R10: A set, clear or toggle write with all-zero data leaves the register unchanged.
- R11: `req_ready` is always high. `rsp_valid` is high in exactly the cycle after each accepted request. Write responses carry zero in `rsp_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset into the bank |
| req_be | input | 4 | Byte enables, must be all ones |
| req_wdata | input | 32 | Write data / bit mask |
| rsp_valid | output | 1 | Response present |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| rsp_err | output | 1 | Access was rejected |

## Verification
The bench targets the alias decode. A design that read the operation from the wrong address bits would turn a set into an overwrite, and the value read back would show it. Zero-data set, clear and toggle writes catch a design that used plain write as its default. Back-to-back write-then-read pairs catch a stale one-cycle read path. Misaligned, partial-byte and out-of-range accesses are each followed by reads of the targeted register, which exposes a design that flags the error but still updates the register.

// File: rtl/alias_bank_pkg.sv
package alias_bank_pkg;
  localparam int DATA_W = 32;
  localparam int BE_W   = DATA_W / 8;

  typedef enum logic [1:0] {
    OP_WRITE  = 2'd0,
    OP_SET    = 2'd1,
    OP_CLEAR  = 2'd2,
    OP_TOGGLE = 2'd3
  } bank_op_e;

  function automatic logic [DATA_W-1:0] combine(bank_op_e op, logic [DATA_W-1:0] cur,
                                               logic [DATA_W-1:0] wd);
    case (op)
      OP_WRITE:  return wd;
      OP_SET:    return cur | wd;
      OP_CLEAR:  return cur & ~wd;
      default:   return cur ^ wd;
    endcase
  endfunction
endpackage

// File: rtl/alias_decode.sv
module alias_decode
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 12,
  localparam int SLOT_W  = ADDR_W - 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [BE_W-1:0]   be,
  output logic [SLOT_W-1:0] slot,
  output bank_op_e          op,
  output logic              bad
);
  localparam logic [SLOT_W:0] LIMIT = (SLOT_W+1)'(NUM_REGS);

  logic misaligned, partial, out_of_range;

  always_comb begin
    slot         = addr[ADDR_W-1:4];
    op           = bank_op_e'(addr[3:2]);
    misaligned   = |addr[1:0];
    partial      = (be != {BE_W{1'b1}});
    out_of_range = ({1'b0, slot} >= LIMIT);
    bad          = misaligned | partial | out_of_range;
  end
endmodule

// File: rtl/alias_slot.sv
module alias_slot
  import alias_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  bank_op_e          op,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= combine(op, q, wdata);
  end

  a_r2_plain_write: assert property (@(posedge clk) disable iff (!rst_n)
    we && op == OP_WRITE |=> q == $past(wdata));
  a_r3_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we && op == OP_SET |=> ((q & $past(wdata)) == $past(wdata)) &&
                           ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  a_r4_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we && op == OP_CLEAR |=> ((q & $past(wdata)) == '0) &&
                             ((q & ~$past(wdata)) == ($past(q) & ~$past(wdata))));
  a_r5_toggle_bits: assert property (@(posedge clk) disable iff (!rst_n)
    we && op == OP_TOGGLE |=> (q ^ $past(q)) == $past(wdata));
  a_r7_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/alias_reg_bank.sv
module alias_reg_bank
  import alias_bank_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int NUM_REGS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err
);
  localparam int SLOT_W = ADDR_W - 4;

  logic [SLOT_W-1:0] slot;
  bank_op_e          op;
  logic              bad;
  logic              accept, hit_wr, hit_rd;
  logic [DATA_W-1:0] regs [NUM_REGS];
  logic [DATA_W-1:0] rd_word;

  assign req_ready = 1'b1;
  assign accept    = req_valid & req_ready;
  assign hit_wr    = accept & req_write & ~bad;
  assign hit_rd    = accept & ~req_write & ~bad;

  alias_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .addr (req_addr),
    .be   (req_be),
    .slot (slot),
    .op   (op),
    .bad  (bad)
  );

  for (genvar k = 0; k < NUM_REGS; k++) begin : g_slot
    logic sel;
    assign sel = hit_wr && (slot == SLOT_W'(k));
    alias_slot u_slot (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (sel),
      .op    (op),
      .wdata (req_wdata),
      .q     (regs[k])
    );
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_REGS; k++)
      if (slot == SLOT_W'(k)) rd_word = regs[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept & bad;
      rsp_rdata <= hit_rd ? rd_word : '0;
    end
  end

  a_r11_one_response: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid));
  a_r11_write_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_write |=> rsp_valid && rsp_rdata == '0);
  a_r9_err_rdata_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid && rsp_rdata == '0);
  a_r7_misaligned_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_addr[1:0] != 2'b00) |=> rsp_err);
  a_r8_partial_flag: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && (req_be != {BE_W{1'b1}}) |=> rsp_err);
endmodule

// File: tb/test_alias_reg_bank.sv
module test_alias_reg_bank;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 8;
  localparam int NUM_REGS   = 12;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [3:0]        req_be = 4'hF;
  logic [31:0]       req_wdata = '0;
  logic              req_ready, rsp_valid, rsp_err;
  logic [31:0]       rsp_rdata;
  logic [31:0]       model [NUM_REGS];
  int                n_checks = 0, n_fail = 0;
  bit                done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  alias_reg_bank #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) i_alias_reg_bank (
    .clk, .rst_n, .req_valid, .req_ready, .req_write, .req_addr, .req_be,
    .req_wdata, .rsp_valid, .rsp_rdata, .rsp_err
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_op(input int op, input logic [31:0] cur,
                                          input logic [31:0] wd);
    if (op == 0) return wd;
    if (op == 1) return cur | wd;
    if (op == 2) return cur & ~wd;
    return cur ^ wd;
  endfunction

  function automatic logic rejected(input logic [ADDR_W-1:0] a, input logic [3:0] be);
    return (a[1:0] != 2'b00) || (be != 4'hF) || (int'(a[ADDR_W-1:4]) >= NUM_REGS);
  endfunction

  task automatic access(input logic wr, input logic [ADDR_W-1:0] a, input logic [3:0] be,
                        input logic [31:0] wd, input string tag);
    int          s   = int'(a[ADDR_W-1:4]);
    logic        bad = rejected(a, be);
    logic [31:0] exp_rd = (!wr && !bad) ? model[s] : 32'h0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    check({tag, " R11 ready"}, 32'(req_ready), 32'h1);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    check({tag, " R11 rsp_valid"}, 32'(rsp_valid), 32'h1);
    check({tag, " err"}, 32'(rsp_err), 32'(bad));
    check({tag, " rdata"}, rsp_rdata, exp_rd);
    if (wr && !bad) model[s] = model_op(int'(a[3:2]), model[s], wd);
  endtask

  function automatic logic [ADDR_W-1:0] addr_of(input int s, input int op);
    return ADDR_W'(s * 16 + op * 4);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++; n_checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int k = 0; k < NUM_REGS; k++) model[k] = '0;
    repeat (3) @(posedge clk);
    #1 check("R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    @(negedge clk) rst_n = 1'b1;
    for (int k = 0; k < NUM_REGS; k++) access(1'b0, addr_of(k, k % 4), 4'hF, '0, "R1 reset value");

    access(1'b1, addr_of(2, 0), 4'hF, 32'hA5A5_0F0F, "R2 plain write");
    for (int op = 0; op < 4; op++) access(1'b0, addr_of(2, op), 4'hF, '0, "R6 alias read");
    access(1'b1, addr_of(2, 1), 4'hF, 32'h0000_F0F0, "R3 set");
    access(1'b0, addr_of(2, 3), 4'hF, '0, "R6 read after set");
    access(1'b1, addr_of(2, 2), 4'hF, 32'hFF00_00FF, "R4 clear");
    access(1'b0, addr_of(2, 1), 4'hF, '0, "R6 read after clear");
    access(1'b1, addr_of(2, 3), 4'hF, 32'hFFFF_0000, "R5 toggle");
    access(1'b0, addr_of(2, 0), 4'hF, '0, "R6 read after toggle");
    for (int op = 1; op < 4; op++) begin
      access(1'b1, addr_of(2, op), 4'hF, 32'h0, "R10 zero-data op");
      access(1'b0, addr_of(2, 0), 4'hF, '0, "R10 value kept");
    end
    access(1'b1, addr_of(2, 0) | 8'h1, 4'hF, 32'h1234_5678, "R7 misaligned write");
    access(1'b0, addr_of(2, 0), 4'hF, '0, "R7 register kept");
    access(1'b0, addr_of(2, 0) | 8'h2, 4'hF, '0, "R7 misaligned read");
    access(1'b1, addr_of(2, 1), 4'h7, 32'hFFFF_FFFF, "R8 partial write");
    access(1'b0, addr_of(2, 0), 4'hF, '0, "R8 register kept");
    access(1'b1, addr_of(NUM_REGS, 0), 4'hF, 32'hDEAD_BEEF, "R9 out-of-range write");
    access(1'b0, addr_of(NUM_REGS, 0), 4'hF, '0, "R9 out-of-range read");
    access(1'b1, addr_of(NUM_REGS - 1, 0), 4'hF, 32'h8000_0001, "R9 last register write");
    access(1'b0, addr_of(NUM_REGS - 1, 2), 4'hF, '0, "R9 last register read");
    access(1'b0, addr_of(0, 0), 4'hF, '0, "R9 register 0 kept");

    for (int i = 0; i < 400; i++) begin
      logic [ADDR_W-1:0] a;
      logic [3:0]        be;
      logic              wr;
      string             tag;
      a  = ADDR_W'($urandom_range(0, 255));
      if ($urandom_range(0, 9) != 0) a[1:0] = 2'b00;
      be = ($urandom_range(0, 9) == 0) ? 4'($urandom_range(0, 14)) : 4'hF;
      wr = 1'($urandom_range(0, 1));
      if (rejected(a, be)) tag = "R7/R8/R9 random reject";
      else if (!wr)        tag = "R6 random read";
      else case (a[3:2])
        2'd0: tag = "R2 random write";
        2'd1: tag = "R3 random set";
        2'd2: tag = "R4 random clear";
        default: tag = "R5 random toggle";
      endcase
      access(wr, a, be, $urandom(), tag);
    end
    for (int k = 0; k < NUM_REGS; k++) access(1'b0, addr_of(k, 0), 4'hF, '0, "R6 final sweep");

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule